// File: doc/BRIEF.md
# Masked Pin-Change Interrupt Unit

This block watches a vector of general-purpose input pins and raises one interrupt request per group of eight pins. Pin `i` belongs to bank `i / 8`. Each bank has its own mask, and only masked-in pins can report a change. A rising or falling transition on any such pin sets that bank's single shared flag. The flag drives the bank's request line only while the bank's enable bit is set. Software clears the flag by writing a one to it, or the interrupt controller clears it by pulsing the bank's acknowledge input.

A second, clock-free path gives a wake output. It compares the raw pins against a snapshot kept by the I/O clock. While that clock is gated in a sleep state, any masked pin that moves away from its snapshot raises the wake output at once. When the clock runs again, the snapshot catches up and the synchronous flag records the event. A pin driven by the device itself is seen like any other pin, so software can trigger an interrupt by toggling an output.

Top module: `pcint_unit`

## Requirements
- R1: After reset, all mask registers, the enable register and the flag register read zero, and `irq_o` and `wake_o` are low.
- R2: Pin `i` belongs to bank `i/8`. A masked change on it sets only bit `i/8` of the flag register, which is read at address `NUM_BANKS`+1.
- R3: A rising edge and a falling edge on a masked pin each set the bank flag.
- R4: A change on a pin whose mask bit is zero never sets a flag and never raises `wake_o`.
- R5: `irq_o[b]` is high exactly when flag `b` is set and bit `b` of the enable register is set. The enable register is at address `NUM_BANKS`.
- R6: Writing the flag register clears each flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R7: A one-cycle pulse on `ack_i[b]` clears flag `b` only.
- R8: With the clock stopped, a change on a masked pin raises `wake_o` without any clock edge, and the flags do not change. Once the clock runs again, the flag is set and `wake_o` returns low.
- R9: The mask for bank `b` is at address `b`. Mask bits for pins at or above `NUM_PINS` read as zero (with 31 pins, bit 7 of the bank 3 mask).
- R10: Turning on a mask bit for a pin whose level changed earlier, while it was unmasked, does not set the flag.
- R11: The flag reads one after the third rising clock edge following a pin change, and not after the second. A flag write that clears the bank in that same cycle loses to the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock; may be stopped during sleep |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NUM_PINS | Pin levels, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: masks 0..NB-1, enable NB, flags NB+1 |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| ack_i | input | NUM_BANKS | Per-bank interrupt acknowledge, clears the flag |
| irq_o | output | NUM_BANKS | Per-bank interrupt request |
| wake_o | output | 1 | Clock-free wake request |

## Verification
The bench builds the unit with its default of 31 pins and two synchronizer stages. This gives four banks, the last of them partial, so the read-as-zero mask bit and the full address map up to the flag register are reached. Two stages fix a flag latency of three edges, which the bench aligns a clearing write against. The bench stops the clock to show the wake path working on its own, and it mixes random mask, enable, pin, clear and acknowledge operations over all four banks.

// File: rtl/pcint_pkg.sv
// Package: shared constants and helpers for the pin-change interrupt unit.
// Assumes banks are always BANK_W pins wide, with the last bank possibly partial.
package pcint_pkg;
    localparam int BANK_W = 8;

    // Returns the mask of implemented pins in bank b for a unit of npins pins.
    function automatic logic [BANK_W-1:0] impl_mask(input int b, input int npins);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int i = 0; i < BANK_W; i++) begin
            if (b * BANK_W + i < npins) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/pcint_sync.sv
// Module: multi-stage level synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; STAGES >= 1. Reset clears every stage.
module pcint_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pins into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Shift the value one stage along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcint_bank.sv
// Module: one bank of eight pins with its mask, snapshot, shared flag and wake term.
// Assumes pin_sync_i is the synchronized copy of pin_raw_i. The snapshot follows
// the synchronized pins on every clock edge, so a pin that moved while unmasked
// already matches its snapshot when its mask bit is turned on.
module pcint_bank
    import pcint_pkg::*;
#(
    parameter logic [BANK_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] pin_raw_i,
    input  logic [BANK_W-1:0] pin_sync_i,
    input  logic              mask_we_i,
    input  logic [BANK_W-1:0] mask_wdata_i,
    input  logic              clr_i,
    output logic [BANK_W-1:0] mask_o,
    output logic              flag_o,
    output logic              wake_o
);
    logic [BANK_W-1:0] mask_q;
    logic [BANK_W-1:0] snap_q;
    logic              flag_q;
    logic              set_evt;

    // Hold the mask, forcing bits of absent pins to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_wdata_i & IMPL;
    end

    // Track the last synchronized pin levels seen by the I/O clock.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= pin_sync_i;
    end

    assign set_evt = |((pin_sync_i ^ snap_q) & mask_q);

    // Shared bank flag: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_i)   flag_q <= 1'b0;
    end

    // Clock-free wake term: a raw pin differs from its snapshot on a masked pin.
    assign wake_o = |((pin_raw_i ^ snap_q) & mask_q);
    assign mask_o = mask_q;
    assign flag_o = flag_q;

    AST_MASK_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~IMPL) == '0); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q); // R11
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_evt) |=> !flag_q); // R6
    AST_UNMASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !wake_o); // R4
endmodule

// File: rtl/pcint_unit.sv
// Module: top of the pin-change interrupt unit. It decodes register writes and
// reads, synchronizes the pins, instantiates one bank per eight pins, and gates
// the requests with the enable register.
// Assumes pins_i is asynchronous to clk and that clk may be stopped; wake_o
// needs no clock.
module pcint_unit
    import pcint_pkg::*;
#(
    parameter int NUM_PINS    = 31,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W,
    localparam int PAD_W      = NUM_BANKS * BANK_W,
    localparam int ADDR_W     = $clog2(NUM_BANKS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pins_i,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BANK_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BANK_W-1:0]    rd_data,
    input  logic [NUM_BANKS-1:0] ack_i,
    output logic [NUM_BANKS-1:0] irq_o,
    output logic                 wake_o
);
    localparam int EN_ADDR   = NUM_BANKS;
    localparam int FLAG_ADDR = NUM_BANKS + 1;

    logic [PAD_W-1:0]     pins_pad;
    logic [PAD_W-1:0]     pins_sync;
    logic [NUM_BANKS-1:0] en_q;
    logic [NUM_BANKS-1:0] flags;
    logic [NUM_BANKS-1:0] bank_wake;
    logic [NUM_BANKS-1:0] bank_clr;
    logic [BANK_W-1:0]    bank_mask [NUM_BANKS];

    // Widen the pin vector to whole banks, tying absent pins low.
    always_comb begin
        pins_pad = '0;
        pins_pad[NUM_PINS-1:0] = pins_i;
    end

    pcint_sync #(.W(PAD_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_pad),
        .q_o   (pins_sync)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic mask_we;
            assign mask_we     = wr_en && (int'(wr_addr) == b);
            assign bank_clr[b] = (wr_en && (int'(wr_addr) == FLAG_ADDR) && wr_data[b])
                                 || ack_i[b];

            pcint_bank #(.IMPL(impl_mask(b, NUM_PINS))) u_bank (
                .clk          (clk),
                .rst_n        (rst_n),
                .pin_raw_i    (pins_pad[b*BANK_W +: BANK_W]),
                .pin_sync_i   (pins_sync[b*BANK_W +: BANK_W]),
                .mask_we_i    (mask_we),
                .mask_wdata_i (wr_data),
                .clr_i        (bank_clr[b]),
                .mask_o       (bank_mask[b]),
                .flag_o       (flags[b]),
                .wake_o       (bank_wake[b])
            );
        end
    endgenerate

    // Hold the per-bank request enables.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    en_q <= '0;
        else if (wr_en && int'(wr_addr) == EN_ADDR)    en_q <= wr_data[NUM_BANKS-1:0];
    end

    // Return the selected register; unused addresses read zero.
    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NUM_BANKS)        rd_data = bank_mask[rd_addr];
        else if (int'(rd_addr) == EN_ADDR)    rd_data[NUM_BANKS-1:0] = en_q;
        else if (int'(rd_addr) == FLAG_ADDR)  rd_data[NUM_BANKS-1:0] = flags;
    end

    assign irq_o  = flags & en_q;
    assign wake_o = |bank_wake;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~en_q) == '0); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i != '0) |=> ((flags & $past(ack_i) & ~$past(flags)) == '0)); // R7
endmodule

// File: tb/tb_pcint_unit.sv
// Bench: directed corner cases plus seeded random operations, checked against a
// model of masks, enables and flags kept entirely in the bench.
module tb_pcint_unit;
    localparam int NP = 31;
    localparam int NB = 4;
    localparam int AW = 3;

    logic          clk_raw = 1'b0;
    logic          clk_run = 1'b1;
    logic          clk;
    logic          rst_n;
    logic [NP-1:0] pins_i;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic [NB-1:0] ack_i;
    logic [NB-1:0] irq_o;
    logic          wake_o;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    logic [7:0]    exp_mask [NB];
    logic [NB-1:0] exp_en;
    logic [NB-1:0] exp_flag;

    always #10 clk_raw = ~clk_raw;
    assign clk = clk_raw & clk_run;

    pcint_unit #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ack_i(ack_i),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    function automatic logic [7:0] impl_of(input int b);
        logic [7:0] m = '0;
        for (int i = 0; i < 8; i++) if (b * 8 + i < NP) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [NB-1:0] hits(input logic [NP-1:0] a, input logic [NP-1:0] c);
        logic [NB*8-1:0] d = '0;
        logic [NB-1:0]   h = '0;
        d[NP-1:0] = a ^ c;
        for (int b = 0; b < NB; b++) h[b] = |(d[b*8 +: 8] & exp_mask[b]);
        return h;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        rd_addr = AW'(a);
        #1;
        d = rd_data;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        if (a < NB) exp_mask[a] = d & impl_of(a);
        else if (a == NB) exp_en = d[NB-1:0];
        else if (a == NB + 1) exp_flag = exp_flag & ~d[NB-1:0];
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        exp_flag = exp_flag | hits(pins_i, v);
        pins_i = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack(input logic [NB-1:0] a);
        ack_i = a;
        @(posedge clk); @(negedge clk);
        ack_i = '0;
        exp_flag = exp_flag & ~a;
    endtask

    task automatic check_state(input string tag);
        logic [7:0] d;
        rd(NB + 1, d);
        chk({tag, " flags"}, d, {4'b0, exp_flag});
        chk({tag, " irq"}, irq_o, exp_flag & exp_en);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [NP-1:0] p;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pins_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; ack_i = '0; exp_en = '0; exp_flag = '0;
        for (int b = 0; b < NB; b++) exp_mask[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and output
        for (int a = 0; a < NB + 2; a++) begin
            rd(a, d);
            chk("R1 register", d, 8'h00);
        end
        chk("R1 irq", irq_o, '0);
        chk("R1 wake", wake_o, 1'b0);

        // R9: mask addresses and the absent pin in the last bank
        wr(0, 8'hFF);
        rd(0, d); chk("R9 mask0", d, 8'hFF);
        wr(3, 8'hFF);
        rd(3, d); chk("R9 mask3 absent bit", d, 8'h7F);

        // R2, R3: rising then falling edge on pin 3, enable off (R5)
        set_pins(NP'(1) << 3);
        check_state("R2 R3 rise");
        chk("R5 irq gated off", irq_o, '0);
        wr(NB + 1, 8'h00);
        check_state("R6 zero write keeps");
        wr(NB + 1, 8'h01);
        check_state("R6 one write clears");
        set_pins('0);
        check_state("R3 fall");
        wr(NB + 1, 8'h0F);

        // R4: unmasked pin 9 moves; R10: masking it afterwards is silent
        wr(NB, 8'h0F);
        set_pins(NP'(1) << 9);
        check_state("R4 unmasked");
        chk("R4 wake", wake_o, 1'b0);
        wr(1, 8'h02);
        repeat (3) @(negedge clk);
        check_state("R10 mask on");
        set_pins('0);
        check_state("R5 irq bank1");
        chk("R2 only bank1", exp_flag, 4'b0010);
        ack(4'b0010);
        check_state("R7 ack");

        // R8: wake with the clock stopped
        clk_run = 1'b0;
        pins_i = 'h1;
        #5;
        chk("R8 wake no clock", wake_o, 1'b1);
        #100;
        rd(NB + 1, d);
        chk("R8 flags frozen", d, 8'h00);
        @(negedge clk_raw);
        clk_run = 1'b1;
        exp_flag = exp_flag | 4'b0001;
        repeat (4) @(negedge clk);
        chk("R8 wake settles", wake_o, 1'b0);
        check_state("R8 flag after clock");
        wr(NB + 1, 8'h0F);

        // R11: latency, and an event beats a clear in the same cycle
        pins_i = '0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(NB + 1, d);
        chk("R11 not after two edges", d, 8'h00);
        wr_en = 1'b1; wr_addr = AW'(NB + 1); wr_data = 8'h0F;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
        rd(NB + 1, d);
        chk("R11 set wins over clear", d, 8'h01);
        repeat (2) @(negedge clk);
        exp_flag = 4'b0001;
        wr(NB + 1, 8'h0F);

        // Random mix of operations over all banks (R2 R5 R6 R7)
        for (int it = 0; it < 60; it++) begin
            int op = $urandom_range(0, 4);
            case (op)
                0: wr($urandom_range(0, NB - 1), 8'($urandom));
                1: wr(NB, 8'($urandom));
                2: begin p = NP'($urandom); set_pins(p); end
                3: wr(NB + 1, 8'($urandom));
                default: ack(NB'($urandom));
            endcase
            check_state("R2 R5 R6 R7 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule